// File: doc/BRIEF.md
# Pixel Output Latency and Blanking Pipeline

This block sits between an upstream converter that produces one 12-bit pixel code per rising edge of the conversion clock and the registered parallel output bus of an imaging front end. Each code travels through a fixed-length register chain and reaches the output register a known number of edges later. The fixed delay lets downstream logic line up pixel codes with the sensor timing that produced them.

Two controls force the bus to zero. An active-low preblank input travels down its own, longer chain of flags. The output is therefore blanked only once that flag reaches the end of its chain, and it recovers only when the flag clears. A stand-by input zeroes the bus at the very next edge. Both pipelines keep shifting underneath it, so data returns at once when stand-by drops.

Top module: `pxl_latency_blank`

## Requirements
- R1: `data_out` is a 12-bit straight-binary code with bit 11 as the MSB, and it carries the input bits unchanged. Codes 0xFFF and 0x800 reach the output intact.
- R2: With preblank high and stand-by low, a code sampled on `code_in` at rising edge t is on `data_out` just after edge t+8. The path is nine registers, counting the sampling edge as the first.
- R3: A low level of `preblank_n` sampled at edge t drives `data_out` to zero just after edge t+10 (eleven registers). It has no effect on the output before that edge.
- R4: A preblank pulse that is low for N consecutive sampled edges zeroes the output for exactly N consecutive cycles.
- R5: When `preblank_n` is sampled high at edge t after being low, `data_out` is still zero after edge t+9. After edge t+10 it shows the code sampled at edge t+2, so data resumes with the blanking delay of eleven edges.
- R6: `standby` sampled high at edge t zeroes `data_out` just after edge t. Both pipelines keep shifting during stand-by. Once `standby` is sampled low at edge t, the output after edge t is the code sampled at edge t-8 (or zero if that sample is blanked).
- R7: `rst_n` sampled low at an edge clears the output register and every pipeline stage at that edge (synchronous reset). After reset the output stays zero until codes sampled after reset arrive.
- R8: Stand-by and preblank combine: the output is zero while either is in effect. Releasing stand-by while a delayed blank flag is still active keeps the output zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; all state updates on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| code_in | input | 12 | Pixel code from the upstream converter |
| preblank_n | input | 1 | Preblank request, active low; high means normal operation |
| standby | input | 1 | Stand-by control, active high |
| data_out | output | 12 | Registered, delayed pixel code or zero |

## Verification
The assertions assume that `rst_n`, `preblank_n` and `standby` are synchronous to `clk` and stable around each rising edge. They also assume that reset is applied before any check that looks one cycle back. The bench changes every input only on the falling edge and begins each run with several reset cycles. No property therefore sees an unknown level or a mid-cycle change. Pixel codes are chosen non-zero wherever blanking windows are counted, so that a zero on the bus can only come from blanking, stand-by or reset.

// File: rtl/pxl_pkg.sv
// Package: shared widths, latencies and the output-source selector used by
// the pixel latency/blanking pipeline. Assumes nothing beyond IEEE 1800.
package pxl_pkg;

    localparam int CODE_W_DEF    = 12;
    localparam int DATA_LAT_DEF  = 9;
    localparam int BLANK_LAT_DEF = 11;

    // Source chosen for the output register on each edge.
    typedef enum logic [1:0] {
        SRC_PASS  = 2'd0,
        SRC_BLANK = 2'd1,
        SRC_STBY  = 2'd2
    } out_src_e;

endpackage

// File: rtl/pxl_delay_line.sv
// Module: pxl_delay_line
// A chain of DEPTH registers of width W that shifts on every rising edge.
// tap_o is the last stage. DEPTH of zero gives a plain wire.
// Assumes a synchronous active-low reset that clears every stage.
module pxl_delay_line #(
    parameter int W     = 12,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] tap_o
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign tap_o = din_i;
        end else begin : g_chain
            logic [W-1:0] stage_q [DEPTH];

            // Purpose: load stage 0 from the input.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= din_i;
            end

            for (genvar i = 1; i < DEPTH; i++) begin : g_stage
                // Purpose: move each value one stage further down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[i] <= '0;
                    else        stage_q[i] <= stage_q[i-1];
                end
            end

            assign tap_o = stage_q[DEPTH-1];

            AST_CHAIN_CLEARED: assert property (@(posedge clk)
                !rst_n |=> tap_o == '0); // R7
        end
    endgenerate

endmodule

// File: rtl/pxl_out_stage.sv
// Module: pxl_out_stage
// Output register. It loads the delayed code unless stand-by or the delayed
// blank flag asks for zero. Stand-by takes precedence and acts on the very
// edge that samples it. Assumes the taps come from pipelines on the same clock.
module pxl_out_stage
    import pxl_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] data_tap_i,
    input  logic         blank_tap_i,
    input  logic         standby_i,
    output logic [W-1:0] data_o
);

    out_src_e src;

    // Purpose: pick what the output register loads on this edge.
    always_comb begin
        if (standby_i)        src = SRC_STBY;
        else if (blank_tap_i) src = SRC_BLANK;
        else                  src = SRC_PASS;
    end

    // Purpose: register the chosen value onto the output bus.
    always_ff @(posedge clk) begin
        if (!rst_n)               data_o <= '0;
        else if (src == SRC_PASS) data_o <= data_tap_i;
        else                      data_o <= '0;
    end

    AST_STBY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> data_o == '0); // R6
    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        blank_tap_i |=> data_o == '0); // R3
    AST_PASS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (!standby_i && !blank_tap_i) |=> data_o == $past(data_tap_i)); // R2
    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> data_o == '0); // R7

endmodule

// File: rtl/pxl_latency_blank.sv
// Module: pxl_latency_blank (top)
// Delays converter codes by DATA_LAT registers and the preblank flag by
// BLANK_LAT registers. Both chains end in one shared output register,
// which is zeroed by the delayed blank flag or by stand-by.
// Assumes all inputs are synchronous to clk and BLANK_LAT >= 1, DATA_LAT >= 1.
module pxl_latency_blank
    import pxl_pkg::*;
#(
    parameter int CODE_W    = CODE_W_DEF,
    parameter int DATA_LAT  = DATA_LAT_DEF,
    parameter int BLANK_LAT = BLANK_LAT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_in,
    input  logic              preblank_n,
    input  logic              standby,
    output logic [CODE_W-1:0] data_out
);

    // The output register is the last stage of both paths.
    localparam int DATA_CHAIN  = DATA_LAT - 1;
    localparam int BLANK_CHAIN = BLANK_LAT - 1;

    logic [CODE_W-1:0] data_tap;
    logic              blank_now;
    logic              blank_tap;

    // Purpose: carry blanking as an active-high flag so reset means "not blanked".
    assign blank_now = ~preblank_n;

    pxl_delay_line #(.W(CODE_W), .DEPTH(DATA_CHAIN)) u_data_line (
        .clk   (clk),
        .rst_n (rst_n),
        .din_i (code_in),
        .tap_o (data_tap)
    );

    pxl_delay_line #(.W(1), .DEPTH(BLANK_CHAIN)) u_blank_line (
        .clk   (clk),
        .rst_n (rst_n),
        .din_i (blank_now),
        .tap_o (blank_tap)
    );

    pxl_out_stage #(.W(CODE_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_tap_i  (data_tap),
        .blank_tap_i (blank_tap),
        .standby_i   (standby),
        .data_o      (data_out)
    );

    AST_STBY_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && $past(!standby)) |=> data_out == '0); // R6
    AST_COMBINED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (standby || blank_tap) |=> data_out == '0); // R8

endmodule

// File: tb/pxl_latency_blank_tb_top.sv
module pxl_latency_blank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HIST       = 1024;

    typedef struct packed {
        logic        rst_n;
        logic        pb_n;
        logic        stby;
        logic [11:0] base;
        logic [7:0]  reps;
    } vec_t;

    localparam vec_t TBL [12] = '{
        '{1'b0, 1'b1, 1'b0, 12'h000, 8'd3},
        '{1'b1, 1'b1, 1'b0, 12'h101, 8'd14},
        '{1'b1, 1'b0, 1'b0, 12'h201, 8'd4},
        '{1'b1, 1'b1, 1'b0, 12'h301, 8'd16},
        '{1'b1, 1'b1, 1'b1, 12'h401, 8'd3},
        '{1'b1, 1'b1, 1'b0, 12'h501, 8'd12},
        '{1'b1, 1'b0, 1'b1, 12'h601, 8'd2},
        '{1'b1, 1'b1, 1'b0, 12'h701, 8'd14},
        '{1'b0, 1'b1, 1'b0, 12'h801, 8'd2},
        '{1'b1, 1'b1, 1'b0, 12'h901, 8'd14},
        '{1'b1, 1'b0, 1'b0, 12'hA01, 8'd1},
        '{1'b1, 1'b1, 1'b0, 12'hB01, 8'd14}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] code_in;
    logic        preblank_n;
    logic        standby;
    logic [11:0] data_out;

    int checks   = 0;
    int failures = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    logic        rst_h [HIST];
    logic        blk_h [HIST];
    logic        st_h  [HIST];
    logic [11:0] cd_h  [HIST];

    always #(CLK_PERIOD/2) clk = ~clk;

    pxl_latency_blank dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_in    (code_in),
        .preblank_n (preblank_n),
        .standby    (standby),
        .data_out   (data_out)
    );

    function automatic bit no_reset(int a, int b);
        for (int i = a; i <= b; i++) if (!rst_h[i]) return 1'b0;
        return 1'b1;
    endfunction

    // Expected output just after edge c, from the requirements.
    function automatic logic [11:0] exp_at(int c, output string tag);
        if (!rst_h[c]) begin tag = "R7"; return '0; end
        if (st_h[c])   begin tag = "R6"; return '0; end
        if (c >= 10 && blk_h[c-10] && no_reset(c-10, c)) begin
            tag = "R3"; return '0;
        end
        tag = "R2";
        if (c >= 8 && no_reset(c-8, c)) return cd_h[c-8];
        tag = "R7";
        return '0;
    endfunction

    task automatic chk(string tag, logic [11:0] act, logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s cycle=%0d actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    // Drive one cycle from the falling edge, then check after the rising edge.
    task automatic step(logic r, logic pb, logic st, logic [11:0] cd);
        string tag;
        logic [11:0] e;
        rst_n = r; preblank_n = pb; standby = st; code_in = cd;
        @(posedge clk);
        rst_h[cyc] = r; blk_h[cyc] = ~pb; st_h[cyc] = st; cd_h[cyc] = cd;
        cyc++;
        @(negedge clk);
        e = exp_at(cyc-1, tag);
        chk(tag, data_out, e);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int t;
        int zeros;
        rst_n = 1'b0; preblank_n = 1'b1; standby = 1'b0; code_in = '0;

        // Table walk: every cycle is checked against the model (R2, R3, R6, R7).
        for (int v = 0; v < 12; v++) begin
            for (int k = 0; k < int'(TBL[v].reps); k++) begin
                step(TBL[v].rst_n, TBL[v].pb_n, TBL[v].stby, TBL[v].base + 12'(k));
            end
        end

        // R7: reset state, then zero until post-reset codes arrive.
        step(1'b0, 1'b1, 1'b0, 12'h0AA);
        chk("R7", data_out, 12'h000);
        for (int k = 0; k < 7; k++) begin
            step(1'b1, 1'b1, 1'b0, 12'h0C1 + 12'(k));
            chk("R7", data_out, 12'h000);
        end
        for (int k = 0; k < 4; k++) step(1'b1, 1'b1, 1'b0, 12'h0D1 + 12'(k));

        // R1: full-scale and MSB-only codes pass through unchanged.
        step(1'b1, 1'b1, 1'b0, 12'hFFF);
        step(1'b1, 1'b1, 1'b0, 12'h800);
        for (int k = 0; k < 7; k++) step(1'b1, 1'b1, 1'b0, 12'h111);
        chk("R1", data_out, 12'hFFF);
        step(1'b1, 1'b1, 1'b0, 12'h111);
        chk("R1", data_out, 12'h800);

        // R4: a three-cycle preblank pulse gives exactly three zero cycles.
        zeros = 0;
        for (int k = 0; k < 17; k++) begin
            step(1'b1, (k < 3) ? 1'b0 : 1'b1, 1'b0, 12'h321 + 12'(k));
            if (data_out == 12'h000) zeros++;
        end
        checks++;
        if (zeros != 3) begin
            failures++;
            $display("FAIL R4 cycle=%0d actual=%0d expected=3 zero cycles", cyc, zeros);
        end

        // R5: release of preblank, data resumes eleven edges later.
        step(1'b1, 1'b0, 1'b0, 12'h3A0);
        step(1'b1, 1'b0, 1'b0, 12'h3A1);
        t = cyc;
        step(1'b1, 1'b1, 1'b0, 12'h3B0);
        for (int k = 1; k <= 9; k++) step(1'b1, 1'b1, 1'b0, 12'h3B0 + 12'(k));
        chk("R5", data_out, 12'h000);
        step(1'b1, 1'b1, 1'b0, 12'h3BA);
        chk("R5", data_out, cd_h[t+2]);

        // R8: stand-by released while the delayed blank flag is still active.
        t = cyc;
        step(1'b1, 1'b0, 1'b0, 12'h4C0);
        for (int k = 1; k <= 9; k++) begin
            step(1'b1, 1'b1, 1'b1, 12'h4C0 + 12'(k));
            chk("R8", data_out, 12'h000);
        end
        step(1'b1, 1'b1, 1'b0, 12'h4CA);
        chk("R8", data_out, 12'h000);
        step(1'b1, 1'b1, 1'b0, 12'h4CB);
        chk("R8", data_out, cd_h[t+3]);

        // R6: stand-by zeroes at once, data returns at once on release.
        for (int k = 0; k < 10; k++) step(1'b1, 1'b1, 1'b0, 12'h5D0 + 12'(k));
        step(1'b1, 1'b1, 1'b1, 12'h5E0);
        chk("R6", data_out, 12'h000);
        t = cyc;
        step(1'b1, 1'b1, 1'b0, 12'h5E1);
        chk("R6", data_out, cd_h[t-8]);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule